// File: doc/BRIEF.md
# Vectored Interrupt Controller with Return Stack

This block decides when a small 4-bit CPU is diverted into an interrupt service routine and where that routine starts. It has three sources. An analog conversion-complete pulse and a timer overflow pulse each raise a request directly. The third source is a falling edge on one port pin, which is synchronised inside the block. Each source has one enable flag and one request flag. Software reads and writes these flags as two 4-bit registers. The block needs both flags of a source at 1 before it interrupts. It then waits for two more instruction slots to complete, and cancels the entry if either of those slots removes the cause.

The block also holds the return stack that the CPU shares between subroutine calls and interrupt entry. Each stack word has 13 bits: the carry flag in the top bit and a 12-bit program counter below it. There are four words, used last in first out. A fifth push silently drops the oldest word. The block also gives the CPU a wake signal for its two sleep modes. All pins are plain control or status strobes, and no pin carries a data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both flag registers read 0, `take` is 0, `vec_addr` is 0x000, `wake` is 0, and the stack top reads as all zeros.
- R2: In both flag registers, bit 3 belongs to the ADC source, bit 2 to the timer and bit 0 to the port pin. Bit 1 always reads 0, even after a write of 1 to it.
- R3: An `adc_done` pulse sets request bit 3 and a `tmr_ovf` pulse sets request bit 2, both at the next clock edge.
- R4: A high-to-low transition on `pin_level` sets request bit 0 within four cycles, but only while `pin_dig_in` is 1. A rising transition, or a falling transition while `pin_dig_in` is 0, leaves bit 0 at 0.
- R5: Writing 0 to a request bit clears it. When a hardware set and that write fall in the same cycle, the bit ends at 1.
- R6: An interrupt is pending when some request bit and its matching enable bit are both 1. `take` rises in the cycle of the third `slot_done` at which a source is pending: instruction N, then I1, then I2. Cycles without `slot_done` neither advance nor cancel this count.
- R7: If a register write during I1 or I2 removes every pending source, no entry happens, and a later pending state needs three fresh slots.
- R8: While `take` is 1, `vec_addr` is 0x001 for ADC, 0x002 for the timer and 0x004 for the port. When several sources are pending, ADC is chosen first, then the timer, then the port. While `take` is 0, `vec_addr` is 0x000, the reset vector.
- R9: The cycle after `take`, every enable bit is 0. A software enable write in the `take` cycle is overridden.
- R10: Entry pushes `{cpu_carry, cpu_pc}`, with the carry in the top bit. `ret_int` pops a word and raises `carry_restore`. `ret_tbl` pops a word with `carry_restore` at 0.
- R11: The stack is shared by `call_push` and entry and is four words deep, last in first out. After five pushes, four pops return the last four words and the oldest is gone. Popping an empty stack leaves the top at zero.
- R12: With `stop_mode` at 0, `wake` is 1 whenever any source is pending. With `stop_mode` at 1, only a pending port source raises `wake`.
- R13: In a `take` cycle, the entry push replaces any `call_push`, `ret_int` or `ret_tbl` strobe in the same cycle, and `carry_restore` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_done | input | 1 | One instruction completes this cycle |
| cpu_carry | input | 1 | Current carry flag, saved on push |
| cpu_pc | input | 12 | Return address, saved on push |
| call_push | input | 1 | Subroutine call pushes a word |
| ret_int | input | 1 | Interrupt return: pop and restore carry |
| ret_tbl | input | 1 | Table return: pop, restore PC only |
| wr_en | input | 1 | Flag register write strobe |
| wr_sel | input | 1 | 0 selects enable register, 1 selects request register |
| wr_data | input | 4 | Write data |
| adc_done | input | 1 | Conversion-complete pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| pin_level | input | 1 | Asynchronous port pin level |
| pin_dig_in | input | 1 | Pin is configured as digital input |
| stop_mode | input | 1 | CPU is in the deeper sleep mode |
| ien_q | output | 4 | Enable register read value |
| irq_q | output | 4 | Request register read value |
| take | output | 1 | Interrupt entry in this slot |
| vec_addr | output | 12 | Entry vector address |
| ret_pc | output | 12 | PC field of the stack top |
| ret_carry | output | 1 | Carry field of the stack top |
| carry_restore | output | 1 | CPU must reload carry from `ret_carry` |
| wake | output | 1 | Leave sleep mode |

## Verification
Two functions can act on the same request bit in one cycle: a hardware set from a source pulse and a software write that clears the bit. The bench raises `adc_done` in the exact cycle that carries a write of 0 to the request register. It then reads the register and expects bit 3 set. A second overlap is entry and a stack strobe in the same slot. The bench issues `ret_int` on the slot that enters. It expects the new word on top, the earlier word still below it, and `carry_restore` low.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int PC_W     = 12;
  localparam int FLAG_W   = 4;
  localparam int ADC_BIT  = 3;
  localparam int TMR_BIT  = 2;
  localparam int PORT_BIT = 0;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 4'b1101;

  typedef struct packed {
    logic            cy;
    logic [PC_W-1:0] pc;
  } stk_word_t;

  // Fixed priority: ADC, then timer, then port.
  function automatic logic [PC_W-1:0] vector_of(input logic [FLAG_W-1:0] pend);
    if (pend[ADC_BIT])       return PC_W'(12'h001);
    else if (pend[TMR_BIT])  return PC_W'(12'h002);
    else if (pend[PORT_BIT]) return PC_W'(12'h004);
    else                     return '0;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic allow,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= cur;
    end
  end

  assign fall = allow & last_q & ~cur;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_vc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] hw_set,
  input  logic              clr_all_en,
  output logic [FLAG_W-1:0] ien_q,
  output logic [FLAG_W-1:0] irq_q,
  output logic [FLAG_W-1:0] pend_next
);
  logic [FLAG_W-1:0] ien_d, irq_d;

  always_comb begin
    ien_d = ien_q;
    irq_d = irq_q;
    if (wr_en && !wr_sel) ien_d = wr_data & FLAG_MASK;
    if (wr_en &&  wr_sel) irq_d = wr_data & FLAG_MASK;
    irq_d = irq_d | (hw_set & FLAG_MASK);
  end

  // Pending view including this cycle's writes and sets.
  assign pend_next = ien_d & irq_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      irq_q <= '0;
    end else begin
      ien_q <= clr_all_en ? '0 : ien_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DELAY_SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_done,
  input  logic pending,
  output logic take
);
  localparam int CNT_W = $clog2(DELAY_SLOTS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_SLOTS);

  logic [CNT_W-1:0] cnt_q;

  assign take = slot_done & pending & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (slot_done) begin
      if (!pending || cnt_q == LAST) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
  import irq_vc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  stk_word_t din,
  output stk_word_t top
);
  // Shift-register stack: entry 0 is the top, entry DEPTH-1 drops on overflow.
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    stk_word_t q;
    stk_word_t from_above, from_below;
    if (i == 0) begin : g_first
      assign from_above = din;
    end else begin : g_mid
      assign from_above = g_lvl[i-1].q;
    end
    if (i == DEPTH-1) begin : g_last
      assign from_below = '0;
    end else begin : g_notlast
      assign from_below = g_lvl[i+1].q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (push) q <= from_above;
      else if (pop)  q <= from_below;
    end
  end

  assign top = g_lvl[0].q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vc_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int ENTRY_DELAY = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_done,
  input  logic              cpu_carry,
  input  logic [PC_W-1:0]   cpu_pc,
  input  logic              call_push,
  input  logic              ret_int,
  input  logic              ret_tbl,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic              adc_done,
  input  logic              tmr_ovf,
  input  logic              pin_level,
  input  logic              pin_dig_in,
  input  logic              stop_mode,
  output logic [FLAG_W-1:0] ien_q,
  output logic [FLAG_W-1:0] irq_q,
  output logic              take,
  output logic [PC_W-1:0]   vec_addr,
  output logic [PC_W-1:0]   ret_pc,
  output logic              ret_carry,
  output logic              carry_restore,
  output logic              wake
);
  logic              port_fall;
  logic [FLAG_W-1:0] hw_set, pend_next, pend_now;
  stk_word_t         push_word, top_word;
  logic              stk_push, stk_pop;

  irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_level), .allow(pin_dig_in), .fall(port_fall)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[ADC_BIT]  = adc_done;
    hw_set[TMR_BIT]  = tmr_ovf;
    hw_set[PORT_BIT] = port_fall;
  end

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hw_set(hw_set), .clr_all_en(take), .ien_q(ien_q), .irq_q(irq_q),
    .pend_next(pend_next)
  );

  irq_entry_seq #(.DELAY_SLOTS(ENTRY_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_done(slot_done), .pending(|pend_next), .take(take)
  );

  assign vec_addr = take ? vector_of(pend_next) : '0;

  assign push_word = '{cy: cpu_carry, pc: cpu_pc};
  assign stk_push  = take | call_push;
  assign stk_pop   = ~take & (ret_int | ret_tbl);

  irq_ret_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop), .din(push_word), .top(top_word)
  );

  assign ret_pc        = top_word.pc;
  assign ret_carry     = top_word.cy;
  assign carry_restore = ~take & ret_int;

  assign pend_now = irq_q & ien_q;
  assign wake     = stop_mode ? pend_now[PORT_BIT] : |pend_now;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slot_done,
  input logic              cpu_carry,
  input logic [PC_W-1:0]   cpu_pc,
  input logic              adc_done,
  input logic              tmr_ovf,
  input logic              stop_mode,
  input logic [FLAG_W-1:0] ien_q,
  input logic [FLAG_W-1:0] irq_q,
  input logic              take,
  input logic [PC_W-1:0]   vec_addr,
  input logic [PC_W-1:0]   ret_pc,
  input logic              ret_carry,
  input logic              wake
);
  a_r2_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[1] == 1'b0) && (irq_q[1] == 1'b0));

  a_r3_adc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> irq_q[ADC_BIT]);

  a_r3_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> irq_q[TMR_BIT]);

  a_r6_take_on_pending_slot: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (slot_done && (|(irq_q & ien_q))));

  a_r8_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr == 12'h001 || vec_addr == 12'h002 || vec_addr == 12'h004));

  a_r8_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (vec_addr == '0));

  a_r9_enables_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ien_q == '0));

  a_r10_entry_push: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ret_pc == $past(cpu_pc) && ret_carry == $past(cpu_carry)));

  a_r12_stop_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && wake) |-> (irq_q[PORT_BIT] && ien_q[PORT_BIT]));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_done(slot_done), .cpu_carry(cpu_carry),
  .cpu_pc(cpu_pc), .adc_done(adc_done), .tmr_ovf(tmr_ovf), .stop_mode(stop_mode),
  .ien_q(ien_q), .irq_q(irq_q), .take(take), .vec_addr(vec_addr),
  .ret_pc(ret_pc), .ret_carry(ret_carry), .wake(wake)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_done, cpu_carry, call_push, ret_int, ret_tbl;
  logic [11:0] cpu_pc;
  logic        wr_en, wr_sel;
  logic [3:0]  wr_data;
  logic        adc_done, tmr_ovf, pin_level, pin_dig_in, stop_mode;
  logic [3:0]  ien_q, irq_q;
  logic        take, ret_carry, carry_restore, wake;
  logic [11:0] vec_addr, ret_pc;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slot_done(slot_done), .cpu_carry(cpu_carry),
    .cpu_pc(cpu_pc), .call_push(call_push), .ret_int(ret_int), .ret_tbl(ret_tbl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .adc_done(adc_done),
    .tmr_ovf(tmr_ovf), .pin_level(pin_level), .pin_dig_in(pin_dig_in),
    .stop_mode(stop_mode), .ien_q(ien_q), .irq_q(irq_q), .take(take),
    .vec_addr(vec_addr), .ret_pc(ret_pc), .ret_carry(ret_carry),
    .carry_restore(carry_restore), .wake(wake)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    slot_done = 0; cpu_carry = 0; cpu_pc = '0; call_push = 0; ret_int = 0; ret_tbl = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0; adc_done = 0; tmr_ovf = 0;
    pin_level = 1; pin_dig_in = 0; stop_mode = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  // Run one slot and check take (sampled mid-cycle, combinational).
  task automatic slot(input logic exp_take, input string rq);
    slot_done = 1;
    #1;
    chk(rq, {15'd0, take}, {15'd0, exp_take});
    tick();
    slot_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ien", {12'd0, ien_q}, 16'h0);
    chk("R1 irq", {12'd0, irq_q}, 16'h0);
    chk("R1 take", {15'd0, take}, 16'h0);
    chk("R1 vec", {4'd0, vec_addr}, 16'h0);
    chk("R1 wake", {15'd0, wake}, 16'h0);
    chk("R1 top", {3'd0, ret_carry, ret_pc}, 16'h0);
  endtask

  task automatic t_layout();
    do_reset();
    wr(0, 4'hF);
    chk("R2 enable bit1 zero", {12'd0, ien_q}, 16'h000D);
    wr(1, 4'h2);
    chk("R2 request bit1 zero", {12'd0, irq_q}, 16'h0);
    adc_done = 1; tick(); adc_done = 0;
    chk("R3 adc sets bit3", {12'd0, irq_q}, 16'h0008);
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    chk("R3 timer sets bit2", {12'd0, irq_q}, 16'h000C);
    wr(1, 4'h8);
    chk("R5 write 0 clears", {12'd0, irq_q}, 16'h0008);
  endtask

  task automatic t_race();
    do_reset();
    wr_en = 1; wr_sel = 1; wr_data = 4'h0; adc_done = 1;
    tick();
    wr_en = 0; adc_done = 0;
    chk("R5 hw set beats clear", {12'd0, irq_q}, 16'h0008);
  endtask

  task automatic t_port();
    do_reset();
    pin_dig_in = 0; pin_level = 0;
    repeat (5) tick();
    chk("R4 analog pin ignored", {15'd0, irq_q[0]}, 16'h0);
    pin_level = 1; repeat (5) tick();
    pin_dig_in = 1;
    pin_level = 0; repeat (5) tick();
    chk("R4 falling edge sets", {15'd0, irq_q[0]}, 16'h1);
    wr(1, 4'h0);
    pin_level = 1; repeat (5) tick();
    chk("R4 rising edge ignored", {15'd0, irq_q[0]}, 16'h0);
  endtask

  task automatic t_entry();
    do_reset();
    wr(0, 4'h8);
    adc_done = 1; tick(); adc_done = 0;
    tick(); tick();
    slot(0, "R6 slot N");
    tick();
    slot(0, "R6 slot I1");
    cpu_pc = 12'h123; cpu_carry = 1;
    slot_done = 1; #1;
    chk("R6 take on I2", {15'd0, take}, 16'h1);
    chk("R8 adc vector", {4'd0, vec_addr}, 16'h0001);
    wr_en = 1; wr_sel = 0; wr_data = 4'hD;
    tick();
    slot_done = 0; wr_en = 0; cpu_carry = 0; cpu_pc = '0;
    chk("R9 enables cleared", {12'd0, ien_q}, 16'h0);
    chk("R10 entry push", {3'd0, ret_carry, ret_pc}, 16'h1123);
  endtask

  task automatic t_cancel();
    do_reset();
    wr(0, 4'h8);
    adc_done = 1; tick(); adc_done = 0;
    slot(0, "R7 slot N");
    wr_en = 1; wr_sel = 0; wr_data = 4'h0;
    slot(0, "R7 I1 clears enable");
    wr_en = 0;
    wr(0, 4'h8);
    slot(0, "R7 restart 1");
    slot(0, "R7 restart 2");
    wr_en = 1; wr_sel = 1; wr_data = 4'h0;
    slot(0, "R7 I2 clears request");
    wr_en = 0;
    chk("R7 enable kept", {12'd0, ien_q}, 16'h0008);
  endtask

  task automatic t_priority();
    do_reset();
    wr(0, 4'hD);
    adc_done = 1; tmr_ovf = 1; tick(); adc_done = 0; tmr_ovf = 0;
    slot(0, "R8 a"); slot(0, "R8 b");
    slot_done = 1; #1;
    chk("R8 adc over timer", {4'd0, vec_addr}, 16'h0001);
    tick(); slot_done = 0;
    wr(1, 4'h4);
    wr(0, 4'hD);
    slot(0, "R8 c"); slot(0, "R8 d");
    slot_done = 1; #1;
    chk("R8 timer vector", {4'd0, vec_addr}, 16'h0002);
    tick(); slot_done = 0;
    wr(1, 4'h0);
    pin_dig_in = 1; pin_level = 0; repeat (5) tick();
    wr(0, 4'h1);
    slot(0, "R8 e"); slot(0, "R8 f");
    slot_done = 1; #1;
    chk("R8 port vector", {4'd0, vec_addr}, 16'h0004);
    tick(); slot_done = 0;
  endtask

  task automatic t_stack();
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      call_push = 1; cpu_pc = 12'h100 + 12'(k); cpu_carry = k[0];
      tick();
    end
    call_push = 0;
    for (int k = 5; k >= 2; k--) begin
      chk("R11 lifo top", {3'd0, ret_carry, ret_pc}, {3'd0, k[0], 12'h100 + 12'(k)});
      if (k[0]) begin
        ret_int = 1; #1;
        chk("R10 ret_int restores carry", {15'd0, carry_restore}, 16'h1);
      end else begin
        ret_tbl = 1; #1;
        chk("R10 ret_tbl keeps carry", {15'd0, carry_restore}, 16'h0);
      end
      tick();
      ret_int = 0; ret_tbl = 0;
    end
    chk("R11 oldest lost", {3'd0, ret_carry, ret_pc}, 16'h0);
    ret_tbl = 1; tick(); ret_tbl = 0;
    chk("R11 empty pop", {3'd0, ret_carry, ret_pc}, 16'h0);
  endtask

  task automatic t_override();
    do_reset();
    call_push = 1; cpu_pc = 12'h0AA; cpu_carry = 0; tick(); call_push = 0;
    wr(0, 4'h8);
    adc_done = 1; tick(); adc_done = 0;
    slot(0, "R13 a"); slot(0, "R13 b");
    slot_done = 1; ret_int = 1; cpu_pc = 12'h3C3; cpu_carry = 1; #1;
    chk("R13 take", {15'd0, take}, 16'h1);
    chk("R13 no carry restore", {15'd0, carry_restore}, 16'h0);
    tick();
    slot_done = 0; ret_int = 0;
    chk("R13 entry word on top", {3'd0, ret_carry, ret_pc}, 16'h13C3);
    ret_tbl = 1; tick(); ret_tbl = 0;
    chk("R13 earlier word kept", {3'd0, ret_carry, ret_pc}, 16'h00AA);
  endtask

  task automatic t_wake();
    do_reset();
    wr(0, 4'h4);
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    #1;
    chk("R12 timer wakes halt", {15'd0, wake}, 16'h1);
    stop_mode = 1; #1;
    chk("R12 timer no stop wake", {15'd0, wake}, 16'h0);
    tick();
    wr(0, 4'h1);
    pin_dig_in = 1; pin_level = 0; repeat (5) tick();
    chk("R12 port wakes stop", {15'd0, wake}, 16'h1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_layout();
    t_race();
    t_port();
    t_entry();
    t_cancel();
    t_priority();
    t_stack();
    t_override();
    t_wake();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule